// File: doc/BRIEF.md
# Two-Bank SDRAM Command Legality Checker

This block watches the control strobes of a synchronous DRAM command bus and judges each command against the state of a device with two banks, A and B. On every rising clock edge it decodes the command, advances a small state machine per bank, and reports one clock later the decoded command, the open or closed status of each bank with its open row, and a flag marking a command that breaks the activation or row-to-column timing rules.

Each bank owns a down-counter for the row-to-column delay, loaded when the bank is activated, so the two banks are timed independently and accesses may alternate between them (or hit the same bank) on every clock. A column access must name the row it expects to find open; a mismatch means the controller skipped the precharge and re-activate a row change needs.

Each bank machine has three states. IDLE is closed. WAIT is open and counting the delay. READY is open with the delay satisfied. Its transitions are these. IDLE goes to WAIT on an activate, which records the row and loads the counter with TRCD-1. WAIT counts down, and goes to READY on the edge after the counter reaches zero. WAIT goes to IDLE on a precharge, and so does READY. Every other command leaves the state unchanged.

Top module: `sdram_bank_guard`

## Requirements
- R1: With cs_n high the command code is 0 (deselect). With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 111 gives 1 (no-op), 011 gives 2 (activate), 010 gives 3 (precharge), 110 gives 6 (burst stop), and 00x gives 7 (other). cmd_o shows the code one clock after the edge that sampled it.
- R2: With cs_n low, ras_n high and cas_n low, we_n high gives code 4 (read) and we_n low gives code 5 (write).
- R3: An activate to a closed bank opens it and records row_addr as its row. A column access to that bank with the same row, sampled TRCD or more edges after the activate edge, is not flagged.
- R4: A column access to a bank sampled fewer than TRCD edges after its activate sets illegal_o.
- R5: A column access to a closed bank sets illegal_o.
- R6: A column access whose row_addr differs from the bank's open row sets illegal_o. Repeated accesses to the open row with no precharge between them are never flagged.
- R7: A precharge closes the addressed bank from either open state, and its row output reads 0. A precharge to a closed bank is not flagged.
- R8: An activate to a bank that is already open, whether counting or ready, sets illegal_o and leaves that bank's status and row unchanged.
- R9: The banks are independent. A command to one bank never changes the other bank's status or row. Both may be open at once, and legal column commands may alternate between them on consecutive clocks.
- R10: After reset both banks are closed, both rows read 0, cmd_o is 0 and illegal_o is 0.
- R11: illegal_o is only ever set for a read, write or activate. Deselect, no-op, burst stop and other commands are never flagged and change no bank state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 1 | Addressed bank: 0 = A, 1 = B |
| row_addr | input | ROW_W | Row opened by an activate, or row expected by a column access |
| cmd_o | output | 3 | Decoded command code of the previous edge |
| illegal_o | output | 1 | Previous edge's command broke a rule |
| bank_open_o | output | 2 | Bit 0 = bank A open, bit 1 = bank B open |
| row_a_o | output | ROW_W | Open row of bank A, 0 when closed |
| row_b_o | output | ROW_W | Open row of bank B, 0 when closed |

## Verification
The case of most interest is the expiry of a bank's delay counter on the same edge as a column command to that bank. That edge decides between a flag under R4 and a clean access under R3. Directed sequences place reads exactly TRCD-1 and TRCD edges after an activate. Random traffic over a small row set then lands precharges, re-activates and ping-pong column commands on counting banks. A bench model kept from the requirements predicts every flag, status and row bit at each edge.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_PRE   = 3'd3,
        CMD_RD    = 3'd4,
        CMD_WR    = 3'd5,
        CMD_BST   = 3'd6,
        CMD_MISC  = 3'd7
    } cmd_t;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_WAIT,
        BK_READY
    } bank_st_t;

    localparam int NUM_BANKS = 2;

endpackage

// File: rtl/sbg_decode.sv
module sbg_decode
    import sbg_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_MISC;
            endcase
        end
    end

endmodule

// File: rtl/sbg_bank.sv
module sbg_bank
    import sbg_pkg::*;
#(
    parameter int TRCD  = 3,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             cmd,
    input  logic             sel,
    input  logic [ROW_W-1:0] row_addr,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q,
    output logic             col_bad,
    output logic             act_bad
);

    localparam int CW = (TRCD > 1) ? $clog2(TRCD) : 1;
    localparam logic [CW-1:0] LOAD = CW'(TRCD - 1);

    bank_st_t         state, nxt;
    logic [CW-1:0]    cnt, cnt_nxt;
    logic [ROW_W-1:0] row_nxt;
    logic             hit, act, pre, ready;

    assign hit = sel && (cmd == CMD_RD || cmd == CMD_WR);
    assign act = sel && (cmd == CMD_ACT);
    assign pre = sel && (cmd == CMD_PRE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BK_IDLE;
            cnt   <= '0;
            row_q <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            row_q <= row_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        row_nxt = row_q;
        unique case (state)
            BK_IDLE: begin
                if (act) begin
                    nxt     = BK_WAIT;
                    cnt_nxt = LOAD;
                    row_nxt = row_addr;
                end
            end
            BK_WAIT: begin
                if (pre) begin
                    nxt     = BK_IDLE;
                    cnt_nxt = '0;
                    row_nxt = '0;
                end else if (cnt == '0) begin
                    nxt = BK_READY;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            BK_READY: begin
                if (pre) begin
                    nxt     = BK_IDLE;
                    row_nxt = '0;
                end
            end
            default: nxt = BK_IDLE;
        endcase
    end

    always_comb begin
        ready   = (state == BK_READY) || (state == BK_WAIT && cnt == '0);
        is_open = (state != BK_IDLE);
        col_bad = hit && (!ready || row_addr != row_q);
        act_bad = act && (state != BK_IDLE);
    end

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
    import sbg_pkg::*;
#(
    parameter int TRCD  = 3,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             bank_sel,
    input  logic [ROW_W-1:0] row_addr,
    output logic [2:0]       cmd_o,
    output logic             illegal_o,
    output logic [1:0]       bank_open_o,
    output logic [ROW_W-1:0] row_a_o,
    output logic [ROW_W-1:0] row_b_o
);

    cmd_t                 cmd;
    logic [NUM_BANKS-1:0] col_bad, act_bad, open_v;
    logic [ROW_W-1:0]     rows [NUM_BANKS];

    sbg_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sbg_bank #(.TRCD(TRCD), .ROW_W(ROW_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd),
            .sel      (bank_sel == b[0]),
            .row_addr (row_addr),
            .is_open  (open_v[b]),
            .row_q    (rows[b]),
            .col_bad  (col_bad[b]),
            .act_bad  (act_bad[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o     <= CMD_DESEL;
            illegal_o <= 1'b0;
        end else begin
            cmd_o     <= cmd;
            illegal_o <= (|col_bad) || (|act_bad);
        end
    end

    assign bank_open_o = open_v;
    assign row_a_o     = rows[0];
    assign row_b_o     = rows[1];

endmodule

// File: rtl/sbg_chk.sv
module sbg_chk
    import sbg_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             bank_sel,
    input logic [ROW_W-1:0] row_addr,
    input logic [2:0]       cmd_o,
    input logic             illegal_o,
    input logic [1:0]       bank_open_o,
    input logic [ROW_W-1:0] row_a_o,
    input logic [ROW_W-1:0] row_b_o
);

    logic is_col, is_act, is_pre;
    assign is_col = !cs_n && ras_n && !cas_n;
    assign is_act = !cs_n && !ras_n && cas_n && we_n;
    assign is_pre = !cs_n && !ras_n && cas_n && !we_n;

    // R1
    desel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_o == 3'd0));

    // R3
    act_opens_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && bank_sel && !bank_open_o[1]) |=>
            (bank_open_o[1] && row_b_o == $past(row_addr)));

    // R5
    closed_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && !bank_sel && !bank_open_o[0]) |=> illegal_o);

    // R6
    row_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && !bank_sel && bank_open_o[0] && row_addr != row_a_o) |=> illegal_o);

    // R7
    pre_closes_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && !bank_sel) |=> (!bank_open_o[0] && row_a_o == '0));

    // R9
    other_bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && bank_sel) |=> ($stable(bank_open_o[0]) && $stable(row_a_o)));

    // R11
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (cmd_o == 3'd2 || cmd_o == 3'd4 || cmd_o == 3'd5));

endmodule

bind sdram_bank_guard sbg_chk #(.ROW_W(ROW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .bank_sel    (bank_sel),
    .row_addr    (row_addr),
    .cmd_o       (cmd_o),
    .illegal_o   (illegal_o),
    .bank_open_o (bank_open_o),
    .row_a_o     (row_a_o),
    .row_b_o     (row_b_o)
);

// File: tb/sim_sdram_bank_guard.sv
module sim_sdram_bank_guard;

    localparam int CLK_NS = 10;
    localparam int TRCD   = 3;
    localparam int ROW_W  = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cs_n, ras_n, cas_n, we_n, bank_sel;
    logic [ROW_W-1:0] row_addr;
    logic [2:0]       cmd_o;
    logic             illegal_o;
    logic [1:0]       bank_open_o;
    logic [ROW_W-1:0] row_a_o, row_b_o;

    int total = 0;
    int bad   = 0;

    int ms [2];
    int mc [2];
    int mr [2];

    always #(CLK_NS/2) clk = ~clk;

    sdram_bank_guard #(.TRCD(TRCD), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .bank_sel(bank_sel), .row_addr(row_addr), .cmd_o(cmd_o),
        .illegal_o(illegal_o), .bank_open_o(bank_open_o),
        .row_a_o(row_a_o), .row_b_o(row_b_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int dec(input logic cs, input logic ras, input logic cas, input logic we);
        if (cs) return 0;
        case ({ras, cas, we})
            3'b111: return 1;
            3'b011: return 2;
            3'b010: return 3;
            3'b101: return 4;
            3'b100: return 5;
            3'b110: return 6;
            default: return 7;
        endcase
    endfunction

    function automatic bit model_ready(input int b);
        return (ms[b] == 2) || (ms[b] == 1 && mc[b] == 0);
    endfunction

    function automatic bit model_bad(input int c, input int b, input int row);
        if (c == 4 || c == 5) return !model_ready(b) || row != mr[b];
        if (c == 2) return ms[b] != 0;
        return 1'b0;
    endfunction

    task automatic model_step(input int c, input int bk, input int row);
        for (int b = 0; b < 2; b++) begin
            bit s = (bk == b);
            case (ms[b])
                0: if (s && c == 2) begin ms[b] = 1; mc[b] = TRCD - 1; mr[b] = row; end
                1: begin
                    if (s && c == 3) begin ms[b] = 0; mc[b] = 0; mr[b] = 0; end
                    else if (mc[b] == 0) ms[b] = 2;
                    else mc[b] = mc[b] - 1;
                end
                default: if (s && c == 3) begin ms[b] = 0; mr[b] = 0; end
            endcase
        end
    endtask

    // Drive at a falling edge, clock once, compare at the next falling edge.
    task automatic step(input logic cs, input logic ras, input logic cas, input logic we,
                        input logic bk, input int row, input string tag);
        int  c;
        bit  eb;
        cs_n = cs; ras_n = ras; cas_n = cas; we_n = we;
        bank_sel = bk; row_addr = ROW_W'(row);
        c  = dec(cs, ras, cas, we);
        eb = model_bad(c, int'(bk), row);
        model_step(c, int'(bk), row);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " cmd"}, int'(cmd_o), c);
        chk({tag, " illegal"}, int'(illegal_o), int'(eb));
        chk({tag, " openA"}, int'(bank_open_o[0]), int'(ms[0] != 0));
        chk({tag, " openB"}, int'(bank_open_o[1]), int'(ms[1] != 0));
        chk({tag, " rowA"}, int'(row_a_o), mr[0]);
        chk({tag, " rowB"}, int'(row_b_o), mr[1]);
    endtask

    task automatic act(input logic bk, input int row, input string tag);
        step(0, 0, 1, 1, bk, row, tag);
    endtask
    task automatic pre(input logic bk, input string tag);
        step(0, 0, 1, 0, bk, 0, tag);
    endtask
    task automatic rd(input logic bk, input int row, input string tag);
        step(0, 1, 0, 1, bk, row, tag);
    endtask
    task automatic wr(input logic bk, input int row, input string tag);
        step(0, 1, 0, 0, bk, row, tag);
    endtask
    task automatic nop(input string tag);
        step(0, 1, 1, 1, 0, 0, tag);
    endtask

    initial begin
        #(CLK_NS * 200000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) begin ms[b] = 0; mc[b] = 0; mr[b] = 0; end
        rst_n = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        bank_sel = 1'b0; row_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 cmd", int'(cmd_o), 0);
        chk("R10 illegal", int'(illegal_o), 0);
        chk("R10 open", int'(bank_open_o), 0);
        chk("R10 rows", int'(row_a_o) + int'(row_b_o), 0);
        rst_n = 1'b1;

        // R5: access to closed bank
        rd(0, 5, "R5");
        // R1: deselect, no-op, burst stop and the other code; R11 no flag
        step(1, 0, 0, 0, 0, 0, "R1 desel");
        nop("R1 nop");
        step(0, 1, 1, 0, 1, 0, "R1 bst R11");
        step(0, 0, 0, 1, 0, 0, "R1 misc R11");
        // R3 / R4: delay boundary on bank A
        act(0, 5, "R3 act");
        rd(0, 5, "R4 early1");
        wr(0, 5, "R4 early2");
        rd(0, 5, "R3 on time");
        // R6: same row repeatedly, then wrong row
        rd(0, 5, "R6 same");
        wr(0, 5, "R6 same R2");
        rd(0, 6, "R6 miss");
        // R8: activate to open bank
        act(0, 9, "R8 reopen");
        // R9: open B, ping-pong after delay
        act(1, 7, "R9 actB");
        act(1, 8, "R8 waitB");
        rd(0, 5, "R9 A");
        rd(1, 7, "R9 B");
        wr(0, 5, "R9 A");
        wr(1, 7, "R9 B R2");
        // R7: precharge closes, then access flagged; precharge closed bank ok
        pre(0, "R7 preA");
        rd(0, 5, "R7 R5 after");
        pre(0, "R7 pre idle");
        // R7: precharge while counting
        act(0, 3, "R7 act");
        pre(0, "R7 pre wait");
        rd(1, 7, "R9 B kept");

        // random traffic
        void'($urandom(32'd12345));
        for (int i = 0; i < 4000; i++) begin
            int  k   = int'($urandom_range(0, 15));
            logic bk = logic'($urandom_range(0, 1));
            int  row = int'($urandom_range(0, 3));
            if (k < 3)       act(bk, row, "R8 rnd act");
            else if (k < 5)  pre(bk, "R7 rnd pre");
            else if (k < 9)  rd(bk, row, "R6 rnd rd");
            else if (k < 13) wr(bk, row, "R2 rnd wr");
            else if (k < 14) nop("R11 rnd nop");
            else if (k < 15) step(0, 1, 1, 0, bk, row, "R11 rnd bst");
            else             step(1, logic'(row[0]), 0, 0, bk, row, "R1 rnd desel");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule